// File: doc/BRIEF.md
# MII to RMII Ethernet Bridge

This block connects a MAC with a 4-bit media-independent interface to a PHY with a 2-bit reduced-pin interface, for 10 and 100 Mbit/s links. Everything runs from the single 50 MHz reference clock that the PHY also receives. From that clock the bridge derives the MAC-side receive and transmit clocks and their resets. At 100 Mbit/s a data slot is one reference cycle and the MAC clocks run at 25 MHz. At 10 Mbit/s a slot lasts `SLOW_REPEAT` reference cycles and the MAC clocks run at 2.5 MHz.

On receive, the PHY's combined carrier/valid line, its error line and its 2-bit data are sampled once per slot, in the last reference cycle of the slot. Dibits are paired into nibbles and handed to the MAC as carrier sense, data valid, error and 4-bit data. On transmit, the MAC's enable and nibble are captured once per MAC clock period and sent to the PHY as two dibits. The MAC's transmit error has no counterpart on the PHY side and is dropped.

Top module: `mii_rmii_bridge`

## Requirements
- R1: While `rst_n` is low, `mac_rx_clk`, `mac_tx_clk`, `mac_rx_valid`, `mac_rx_err`, `mac_rx_nib`, `mac_crs`, `phy_tx_en` and `phy_tx_dibit` are 0, and `mac_rx_rst` and `mac_tx_rst` are 1.
- R2: With `fast_mode` = 1, every slot is one reference cycle. Each MAC clock is low during the first slot of a two-slot period and high during the second, so it toggles on every reference cycle.
- R3: `mac_rx_rst` and `mac_tx_rst` stay at 1 until `RST_PERIODS` (default 4) complete MAC clock periods have passed after reset. They then fall together and stay at 0.
- R4: The receiver waits until the carrier/valid line is high and the sampled dibit is 01. That dibit becomes the first (low) dibit of the first nibble, and the next dibit is its high half: nibble = {second, first}. Dibits sampled before it, and any carrier episode without a 01 dibit, produce no valid nibble.
- R5: `mac_rx_valid`, `mac_rx_nib` and `mac_rx_err` change only as the MAC receive clock falls, at the end of a period. Each completed nibble appears there, either at the end of the period in which it completes or at the end of the next period.
- R6: A nibble counts as valid when the carrier/valid line is high on at least one of its two dibits. The first nibble with the line low on both dibits is not valid, and it ends the frame.
- R7: `mac_rx_err` is 1 with a valid nibble when the PHY error line was high on either of its dibits. It is 0 whenever `mac_rx_valid` is 0.
- R8: `mac_crs` takes the carrier/valid sample of every slot outside a frame. Inside a frame it takes only the sample of the first dibit of each nibble.
- R9: At the end of each MAC clock period, `mac_tx_en` and `mac_tx_nib` are captured. `phy_tx_dibit` then shows `mac_tx_nib[1:0]` for the next slot and `mac_tx_nib[3:2]` for the slot after, with `phy_tx_en` equal to the captured enable in both slots.
- R10: `mac_tx_err` has no effect on `phy_tx_en` or `phy_tx_dibit`.
- R11: With `fast_mode` = 0, a slot lasts `SLOW_REPEAT` (default 10) reference cycles. PHY inputs are sampled once per slot, transmit dibits are held for the whole slot, and a MAC clock period is 2×`SLOW_REPEAT` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | 50 MHz reference clock shared with the PHY |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_mode | input | 1 | 1 = 100 Mbit/s, 0 = 10 Mbit/s |
| phy_crs_valid | input | 1 | PHY combined carrier/data-valid |
| phy_rx_err | input | 1 | PHY receive error |
| phy_rx_dibit | input | 2 | PHY receive data |
| phy_tx_en | output | 1 | Transmit enable to PHY |
| phy_tx_dibit | output | 2 | Transmit data to PHY |
| mac_rx_clk | output | 1 | MAC receive clock |
| mac_rx_rst | output | 1 | MAC receive reset, active high |
| mac_crs | output | 1 | MAC carrier sense |
| mac_rx_valid | output | 1 | MAC receive data valid |
| mac_rx_err | output | 1 | MAC receive error |
| mac_rx_nib | output | 4 | MAC receive nibble |
| mac_tx_clk | output | 1 | MAC transmit clock |
| mac_tx_rst | output | 1 | MAC transmit reset, active high |
| mac_tx_en | input | 1 | MAC transmit enable |
| mac_tx_err | input | 1 | MAC transmit error (not forwarded) |
| mac_tx_nib | input | 4 | MAC transmit nibble |

## Verification
Nibble completion and the end-of-period hand-over to the MAC can fall in the same reference cycle. This happens when the 01 alignment dibit lands in the first slot of a MAC clock period; otherwise the nibble waits one slot in a holding register. The bench varies the number of leading 00 dibits so that both alignments occur, at both speeds. Its queue-based model predicts every output on every cycle, and a separate check confirms that receive outputs move only when the receive clock falls. Transmit serialization runs alongside receive throughout, including phases where transmit error toggles.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DIBIT_W = 2;
  localparam int NIB_W   = 2 * DIBIT_W;
  localparam logic [DIBIT_W-1:0] ALIGN_DIBIT = 2'b01;

  typedef struct packed {
    logic             valid;
    logic             err;
    logic [NIB_W-1:0] data;
  } nib_t;

  // First dibit received is the low half of the nibble.
  function automatic logic [NIB_W-1:0] join_dibits(input logic [DIBIT_W-1:0] first,
                                                    input logic [DIBIT_W-1:0] second);
    return {second, first};
  endfunction

  // A nibble stays in the frame if carrier/valid was seen on either dibit.
  function automatic logic keep_frame(input logic crs_first, input logic crs_second);
    return crs_first | crs_second;
  endfunction

  function automatic logic [DIBIT_W-1:0] low_dibit(input logic [NIB_W-1:0] nib);
    return nib[DIBIT_W-1:0];
  endfunction

  function automatic logic [DIBIT_W-1:0] high_dibit(input logic [NIB_W-1:0] nib);
    return nib[NIB_W-1:DIBIT_W];
  endfunction
endpackage

// File: rtl/mrb_slot_timer.sv
module mrb_slot_timer #(
  parameter int SLOW_REPEAT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_mode,
  output logic slot_tick,
  output logic phase,
  output logic period_end
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W = $clog2(SLOW_REPEAT + 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_REPEAT - 1);

  logic [CNT_W-1:0] pos_q;
  logic             phase_q;

  // Last reference cycle of a slot; >= keeps a speed change mid-slot safe.
  function automatic logic slot_done(input logic fast, input logic [CNT_W-1:0] pos);
    return fast || (pos >= SLOW_LAST);
  endfunction

  assign slot_tick  = slot_done(fast_mode, pos_q);
  assign phase      = phase_q;
  assign period_end = slot_tick & phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      phase_q <= 1'b0;
    end else if (slot_tick) begin
      pos_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      pos_q   <= pos_q + 1'b1;
    end
  end

  // R2: at 100 Mbit/s the MAC clock toggles every reference cycle
  assert_fast_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fast_mode |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/mrb_reset_seq.sv
module mrb_reset_seq #(
  parameter int RST_PERIODS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic period_end,
  output logic mac_rst
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int RW = $clog2(RST_PERIODS + 1);
  localparam logic [RW-1:0] LAST_PERIOD = RW'(RST_PERIODS - 1);

  logic [RW-1:0] seen_q;
  logic          rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      rst_q  <= 1'b1;
    end else if (period_end && rst_q) begin
      seen_q <= seen_q + 1'b1;
      if (seen_q == LAST_PERIOD) rst_q <= 1'b0;
    end
  end

  assign mac_rst = rst_q;

  // R3: once released, the MAC resets stay released
  assert_rst_stays_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q |=> !rst_q);
endmodule

// File: rtl/mrb_rx_align.sv
module mrb_rx_align
  import mrb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_tick,
  input  logic               period_end,
  input  logic               crs_valid,
  input  logic               rx_err,
  input  logic [DIBIT_W-1:0] rx_dibit,
  output logic               crs,
  output logic               valid,
  output logic               err,
  output logic [NIB_W-1:0]   nib
);
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic {SEEK, FRAME} rx_state_t;

  rx_state_t          state_q;
  logic               second_q;
  logic [DIBIT_W-1:0] lo_q;
  logic               crs_first_q;
  logic               err_first_q;
  logic               crs_q;
  nib_t               pend_q;
  nib_t               out_q;

  // Named events for the assertions and for reading the waveform.
  logic align_hit;
  logic nib_done;
  logic nib_keep;
  nib_t fresh;
  nib_t next_out;

  always_comb begin
    align_hit   = slot_tick && (state_q == SEEK) && crs_valid && (rx_dibit == ALIGN_DIBIT);
    nib_done    = slot_tick && (state_q == FRAME) && second_q;
    nib_keep    = keep_frame(crs_first_q, crs_valid);
    fresh.valid = nib_done && nib_keep;
    fresh.err   = fresh.valid && (err_first_q || rx_err);
    fresh.data  = fresh.valid ? join_dibits(lo_q, rx_dibit) : '0;
    if (fresh.valid)       next_out = fresh;
    else if (pend_q.valid) next_out = pend_q;
    else                   next_out = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SEEK;
      second_q    <= 1'b0;
      lo_q        <= '0;
      crs_first_q <= 1'b0;
      err_first_q <= 1'b0;
      crs_q       <= 1'b0;
      pend_q      <= '0;
      out_q       <= '0;
    end else begin
      if (slot_tick) begin
        if (state_q == SEEK || !second_q) crs_q <= crs_valid;
        case (state_q)
          SEEK: begin
            if (align_hit) begin
              state_q     <= FRAME;
              second_q    <= 1'b1;
              lo_q        <= rx_dibit;
              crs_first_q <= 1'b1;
              err_first_q <= rx_err;
            end
          end
          FRAME: begin
            if (!second_q) begin
              second_q    <= 1'b1;
              lo_q        <= rx_dibit;
              crs_first_q <= crs_valid;
              err_first_q <= rx_err;
            end else begin
              second_q <= 1'b0;
              if (!nib_keep) state_q <= SEEK;
            end
          end
        endcase
      end
      if (period_end) begin
        out_q  <= next_out;
        pend_q <= '0;
      end else if (fresh.valid) begin
        pend_q <= fresh;
      end
    end
  end

  assign crs   = crs_q;
  assign valid = out_q.valid;
  assign err   = out_q.err;
  assign nib   = out_q.data;

  // R4: the first valid nibble of a frame starts with the alignment dibit
  assert_first_nib_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q.valid) |-> (out_q.data[DIBIT_W-1:0] == ALIGN_DIBIT));

  // R5: MAC receive outputs only move at the end of a clock period
  assert_rx_out_at_period_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(out_q));

  // R7: no error is reported without data valid
  assert_err_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.err |-> out_q.valid);
endmodule

// File: rtl/mrb_tx_serial.sv
module mrb_tx_serial
  import mrb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_tick,
  input  logic               phase,
  input  logic               period_end,
  input  logic               tx_en,
  input  logic [NIB_W-1:0]   tx_nib,
  output logic               phy_en,
  output logic [DIBIT_W-1:0] phy_dibit
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DIBIT_W-1:0] hi_q;
  logic [DIBIT_W-1:0] dib_q;
  logic               en_hold_q;
  logic               en_q;
  logic               second_slot_start;

  // Start of the second slot of a period: switch to the high dibit.
  assign second_slot_start = slot_tick && !phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= '0;
      dib_q     <= '0;
      en_hold_q <= 1'b0;
      en_q      <= 1'b0;
    end else if (period_end) begin
      dib_q     <= low_dibit(tx_nib);
      hi_q      <= high_dibit(tx_nib);
      en_q      <= tx_en;
      en_hold_q <= tx_en;
    end else if (second_slot_start) begin
      dib_q     <= hi_q;
      en_q      <= en_hold_q;
    end
  end

  assign phy_en    = en_q;
  assign phy_dibit = dib_q;

  // R9: enable is the same for both dibits of one nibble
  assert_tx_en_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    second_slot_start |=> $stable(en_q));
endmodule

// File: rtl/mii_rmii_bridge.sv
module mii_rmii_bridge
  import mrb_pkg::*;
#(
  parameter int SLOW_REPEAT = 10,
  parameter int RST_PERIODS = 4
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               fast_mode,
  input  logic               phy_crs_valid,
  input  logic               phy_rx_err,
  input  logic [DIBIT_W-1:0] phy_rx_dibit,
  output logic               phy_tx_en,
  output logic [DIBIT_W-1:0] phy_tx_dibit,
  output logic               mac_rx_clk,
  output logic               mac_rx_rst,
  output logic               mac_crs,
  output logic               mac_rx_valid,
  output logic               mac_rx_err,
  output logic [NIB_W-1:0]   mac_rx_nib,
  output logic               mac_tx_clk,
  output logic               mac_tx_rst,
  input  logic               mac_tx_en,
  input  logic               mac_tx_err,
  input  logic [NIB_W-1:0]   mac_tx_nib
);
  timeunit 1ns;
  timeprecision 1ps;

  logic slot_tick;
  logic phase;
  logic period_end;
  logic mac_rst;

  // The reduced-pin side has no transmit error line.
  logic unused_tx_err;
  assign unused_tx_err = mac_tx_err;

  mrb_slot_timer #(.SLOW_REPEAT(SLOW_REPEAT)) u_timer (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .fast_mode  (fast_mode),
    .slot_tick  (slot_tick),
    .phase      (phase),
    .period_end (period_end)
  );

  mrb_reset_seq #(.RST_PERIODS(RST_PERIODS)) u_rst (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .period_end (period_end),
    .mac_rst    (mac_rst)
  );

  mrb_rx_align u_rx (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .slot_tick  (slot_tick),
    .period_end (period_end),
    .crs_valid  (phy_crs_valid),
    .rx_err     (phy_rx_err),
    .rx_dibit   (phy_rx_dibit),
    .crs        (mac_crs),
    .valid      (mac_rx_valid),
    .err        (mac_rx_err),
    .nib        (mac_rx_nib)
  );

  mrb_tx_serial u_tx (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .slot_tick  (slot_tick),
    .phase      (phase),
    .period_end (period_end),
    .tx_en      (mac_tx_en),
    .tx_nib     (mac_tx_nib),
    .phy_en     (phy_tx_en),
    .phy_dibit  (phy_tx_dibit)
  );

  assign mac_rx_clk = phase;
  assign mac_tx_clk = phase;
  assign mac_rx_rst = mac_rst;
  assign mac_tx_rst = mac_rst;
endmodule

// File: tb/sim_mii_rmii_bridge.sv
module sim_mii_rmii_bridge;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SLOW = 10;
  localparam int RSTP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_mode = 1'b1;
  logic       crs_in = 1'b0, rxer_in = 1'b0;
  logic [1:0] rxd_in = 2'b00;
  logic       txen_in = 1'b0, txer_in = 1'b0;
  logic [3:0] txd_in = 4'h0;
  logic       p_en;
  logic [1:0] p_dib;
  logic       rclk, rrst, crs, rval, rerr, tclk, trst;
  logic [3:0] rnib;

  int total = 0;
  int fails = 0;
  bit done = 0;
  bit tx_run = 0;
  bit err_on = 0;

  always #10 clk = ~clk;

  mii_rmii_bridge #(.SLOW_REPEAT(SLOW), .RST_PERIODS(RSTP)) u0 (
    .ref_clk(clk), .rst_n(rst_n), .fast_mode(fast_mode),
    .phy_crs_valid(crs_in), .phy_rx_err(rxer_in), .phy_rx_dibit(rxd_in),
    .phy_tx_en(p_en), .phy_tx_dibit(p_dib),
    .mac_rx_clk(rclk), .mac_rx_rst(rrst), .mac_crs(crs), .mac_rx_valid(rval),
    .mac_rx_err(rerr), .mac_rx_nib(rnib), .mac_tx_clk(tclk), .mac_tx_rst(trst),
    .mac_tx_en(txen_in), .mac_tx_err(txer_in), .mac_tx_nib(txd_in));

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int slot_pos, periods;
  bit half;
  bit in_frame, have_lo, lo_crs, lo_err;
  int lo_dib;
  int nibq[$];
  int e_val, e_nib, e_err, e_crs, e_txd, e_txen, t_hi, t_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      slot_pos = 0; half = 0; periods = 0;
      in_frame = 0; have_lo = 0; lo_crs = 0; lo_err = 0; lo_dib = 0;
      nibq.delete();
      e_val = 0; e_nib = 0; e_err = 0; e_crs = 0;
      e_txd = 0; e_txen = 0; t_hi = 0; t_en = 0;
    end else begin
      int len;
      len = fast_mode ? 1 : SLOW;
      if (slot_pos >= len - 1) begin
        // receive: carrier sense
        if (!in_frame || !have_lo) e_crs = crs_in;
        // receive: nibble assembly
        if (!in_frame) begin
          if (crs_in && rxd_in == 2'b01) begin
            in_frame = 1; have_lo = 1; lo_dib = 1; lo_crs = 1; lo_err = rxer_in;
          end
        end else if (!have_lo) begin
          have_lo = 1; lo_dib = rxd_in; lo_crs = crs_in; lo_err = rxer_in;
        end else begin
          have_lo = 0;
          if (lo_crs || crs_in) nibq.push_back(((lo_err | rxer_in) << 4) | (rxd_in * 4 + lo_dib));
          else in_frame = 0;
        end
        if (half) begin
          if (nibq.size() > 0) begin
            int x;
            x = nibq.pop_front();
            e_val = 1; e_nib = x & 15; e_err = (x >> 4) & 1;
          end else begin
            e_val = 0; e_nib = 0; e_err = 0;
          end
          e_txd = txd_in % 4; e_txen = txen_in; t_hi = txd_in / 4; t_en = txen_in;
          if (periods < RSTP) periods++;
        end else begin
          e_txd = t_hi; e_txen = t_en;
        end
        slot_pos = 0;
        half = !half;
      end else begin
        slot_pos++;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  int pv_clk = 0, pv_val = 0, pv_nib = 0;
  bit started = 0;
  always @(negedge clk) begin
    if (started && !done) begin
      string ctag, ttag;
      ctag = !rst_n ? "R1" : (fast_mode ? "R2" : "R11");
      ttag = !rst_n ? "R1" : (err_on ? "R10" : (fast_mode ? "R9" : "R11"));
      check(ctag, "mac_rx_clk", rclk, half);
      check(ctag, "mac_tx_clk", tclk, half);
      check(!rst_n ? "R1" : "R3", "mac_rx_rst", rrst, periods < RSTP);
      check(!rst_n ? "R1" : "R3", "mac_tx_rst", trst, periods < RSTP);
      check("R6", "mac_rx_valid", rval, e_val);
      check("R4", "mac_rx_nib", rnib, e_nib);
      check("R7", "mac_rx_err", rerr, e_err);
      check("R8", "mac_crs", crs, e_crs);
      check(ttag, "phy_tx_dibit", p_dib, e_txd);
      check(ttag, "phy_tx_en", p_en, e_txen);
      if (!(pv_clk == 1 && rclk == 0)) begin
        check("R5", "rx valid moved without clock fall", rval, pv_val);
        check("R5", "rx nibble moved without clock fall", rnib, pv_nib);
      end
    end
    pv_clk = rclk; pv_val = rval; pv_nib = rnib;
  end

  // ---------------- stimulus ----------------
  task automatic put(input bit c, input bit e, input logic [1:0] d);
    repeat (fast_mode ? 1 : SLOW) begin
      @(negedge clk);
      crs_in = c; rxer_in = e; rxd_in = d;
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input int err_dibit);
    for (int k = 0; k < 4; k++) put(1'b1, k == err_dibit, b[2*k +: 2]);
  endtask

  task automatic rx_frame(input int pre00, input int nbytes, input int err_byte, input int toggles);
    for (int i = 0; i < pre00; i++) put(1'b1, 1'b0, 2'b00);
    for (int i = 0; i < 7; i++) put_byte(8'h55, -1);
    put_byte(8'hD5, -1);
    for (int i = 0; i < nbytes; i++) put_byte(8'h3C + 8'(i * 37), (i == err_byte) ? 1 : -1);
    for (int t = 0; t < toggles; t++) begin
      put(1'b0, 1'b0, 2'b10);
      put(1'b1, 1'b0, 2'b11);
    end
    put(1'b0, 1'b0, 2'b00);
    put(1'b0, 1'b0, 2'b00);
    for (int i = 0; i < 4; i++) put(1'b0, 1'b0, 2'b00);
  endtask

  task automatic tx_stream();
    logic [15:0] lf;
    lf = 16'hACE1;
    while (tx_run) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      txd_in  = lf[3:0];
      txen_in = lf[5] | lf[9];
      txer_in = err_on ? lf[7] : 1'b0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit saw_valid;
    @(posedge clk);
    started = 1;
    repeat (3) @(negedge clk);
    // R1: reset state seen at the ports
    check("R1", "reset mac_rx_valid", rval, 0);
    check("R1", "reset phy_tx_en", p_en, 0);
    check("R1", "reset mac_rx_rst", rrst, 1);
    check("R1", "reset mac_tx_rst", trst, 1);
    check("R1", "reset mac_rx_clk", rclk, 0);
    rst_n = 1'b1;
    tx_run = 1;
    fork tx_stream(); join_none
    // R3: resets released after the programmed number of periods
    repeat (2 * RSTP + 2) @(negedge clk);
    check("R3", "rx reset released", rrst, 0);

    // R4: false carrier with no alignment dibit yields nothing valid
    saw_valid = 0;
    for (int i = 0; i < 6; i++) begin put(1'b1, 1'b0, 2'b00); if (rval) saw_valid = 1; end
    for (int i = 0; i < 4; i++) begin put(1'b0, 1'b0, 2'b00); if (rval) saw_valid = 1; end
    check("R4", "false carrier valid", saw_valid, 0);

    // fast mode, both nibble alignments against the MAC clock
    rx_frame(3, 5, 2, 1);
    rx_frame(2, 4, -1, 2);
    repeat (3) @(negedge clk);
    rx_frame(0, 3, 0, 0);
    // R10: transmit error toggling
    err_on = 1;
    rx_frame(1, 3, -1, 1);
    err_on = 0;
    // R11: slow mode
    fast_mode = 1'b0;
    rx_frame(3, 2, 1, 1);
    rx_frame(2, 2, -1, 0);
    fast_mode = 1'b1;
    rx_frame(1, 2, -1, 1);
    repeat (40) @(negedge clk);
    tx_run = 0;
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule